// File: doc/BRIEF.md
# Accumulator Processor with Stepped Register-Transfer Control

This block is a small accumulator machine. Each instruction runs as a fixed series of single register transfers: the program counter is copied into the memory address register, and the instruction word is read into the instruction register. The program counter is then incremented, and only after that does the execute phase start. The machine drives a synchronous single-port word memory with one cycle of read latency. It also has an input data port, an output data port and a sticky halted flag.

Each instruction word holds a 4-bit opcode and a 12-bit address or operand. The machine implements nine operations:

- moving a word between memory and the accumulator (load and store);
- two's complement add and subtract of a memory word;
- reading the input port and writing the output port;
- a jump;
- a conditional skip that compares the signed accumulator with zero;
- halt.

Every other opcode does nothing.

Top module: `acc_cpu`

## Requirements
- R1: While rst_ni is low, all registers are cleared: mem_addr_o, out_data_o and halted_o read 0 and mem_we_o is low. After reset is released, the first fetch is from address 0.
- R2: Each instruction runs in this order: MAR <- PC, one wait step, IR <- memory, PC <- PC + 1, then the execute steps. A store at address 0 therefore raises mem_we_o in the 7th cycle after reset is released, with mem_addr_o equal to the store target, and not in the 6th cycle.
- R3: Word format is opcode in bits 15:12 and operand X in bits 11:0. Load (1) sets AC <- M[X]. Add (3) and subtract (4) set AC <- AC ± M[X], two's complement and wrapping at 16 bits.
- R4: Store (2) writes AC to address X. It runs MAR <- X, then MBR <- AC, then one write cycle with mem_we_o high for exactly one cycle and mem_wdata_o equal to MBR.
- R5: Input (5) captures in_data_i into the input register and then copies it into AC. Output (6) copies AC to out_data_o, which holds that value until the next output.
- R6: Skip (8) takes its condition code from bits 11:10. Code 00 skips when AC < 0, 01 when AC == 0, and 11 when AC > 0, all signed. Code 10 never skips. A skip advances PC one further word.
- R7: Jump (9) loads PC with X after the increment phase, so the word after the jump is never executed.
- R8: Halt (7) sets halted_o. halted_o stays set until reset. While halted, no memory write occurs and mem_addr_o and out_data_o do not change.
- R9: Opcodes 0 and 10 to 15 change no register; AC keeps its value through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 12 | Memory address (MAR) |
| mem_wdata_o | output | 16 | Memory write data (MBR) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after address |
| in_data_i | input | 16 | Input port |
| out_data_o | output | 16 | Output register |
| halted_o | output | 1 | Sticky halt flag |

## Verification
The assertions assume that the memory returns the word at mem_addr_o exactly one cycle after that address was presented. The bench memory model is a registered array that follows this timing. The assertions also assume that in_data_i is stable during the execute step of an input instruction; the bench sets it before reset and never changes it. The programs use only addresses inside the modelled 256 words, so every read returns a defined value.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_INC, S_E0, S_E1, S_E2, S_E3, S_HALT
  } step_e;

  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_STORE = 4'd2;
  localparam logic [3:0] OP_ADD   = 4'd3;
  localparam logic [3:0] OP_SUB   = 4'd4;
  localparam logic [3:0] OP_IN    = 4'd5;
  localparam logic [3:0] OP_OUT   = 4'd6;
  localparam logic [3:0] OP_HALT  = 4'd7;
  localparam logic [3:0] OP_SKIP  = 4'd8;
  localparam logic [3:0] OP_JUMP  = 4'd9;
endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] op_i,
  output step_e      step_o
);
  step_e step_d;

  always_comb begin
    step_d = step_o;
    case (step_o)
      S_F0:  step_d = S_F1;
      S_F1:  step_d = S_F2;
      S_F2:  step_d = S_INC;
      S_INC: step_d = S_E0;
      S_E0: begin
        case (op_i)
          OP_HALT: step_d = S_HALT;
          OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_IN: step_d = S_E1;
          default: step_d = S_F0;
        endcase
      end
      S_E1:   step_d = (op_i == OP_IN) ? S_F0 : S_E2;
      S_E2:   step_d = (op_i == OP_STORE) ? S_F0 : S_E3;
      S_E3:   step_d = S_F0;
      S_HALT: step_d = S_HALT;
      default: step_d = S_F0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_o <= S_F0;
    else         step_o <= step_d;
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] ac_i,
  input  logic [DW-1:0] mbr_i,
  input  logic          sub_i,
  input  logic [1:0]    cond_i,
  output logic [DW-1:0] res_o,
  output logic          take_o
);
  logic neg, zero;

  assign res_o = sub_i ? (ac_i - mbr_i) : (ac_i + mbr_i);
  assign neg   = ac_i[DW-1];
  assign zero  = (ac_i == '0);

  always_comb begin
    case (cond_i)
      2'b00:   take_o = neg;
      2'b01:   take_o = zero;
      2'b11:   take_o = !neg && !zero;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned OPW = 4,
  parameter int unsigned AW  = 12,
  localparam int unsigned DW = OPW + AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] in_data_i,
  output logic [DW-1:0] out_data_o,
  output logic          halted_o
);
  step_e         step;
  logic [DW-1:0] ac_q, mbr_q, ir_q, in_q, out_q;
  logic [AW-1:0] mar_q, pc_q;
  logic          halt_q;
  logic [3:0]    op;
  logic [AW-1:0] opnd;
  logic [DW-1:0] alu_res;
  logic          skip_take;

  assign op   = 4'(ir_q[DW-1 -: OPW]);
  assign opnd = ir_q[AW-1:0];

  acc_cpu_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .step_o (step)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .ac_i   (ac_q),
    .mbr_i  (mbr_q),
    .sub_i  (op == OP_SUB),
    .cond_i (ir_q[AW-1 -: 2]),
    .res_o  (alu_res),
    .take_o (skip_take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q   <= '0;
      mbr_q  <= '0;
      ir_q   <= '0;
      in_q   <= '0;
      out_q  <= '0;
      mar_q  <= '0;
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else begin
      case (step)
        S_F0:  mar_q <= pc_q;
        S_F2:  ir_q  <= mem_rdata_i;
        S_INC: pc_q  <= pc_q + 1'b1;
        S_E0: begin
          case (op)
            OP_LOAD, OP_STORE, OP_ADD, OP_SUB: mar_q <= opnd;
            OP_IN:   in_q   <= in_data_i;
            OP_OUT:  out_q  <= ac_q;
            OP_HALT: halt_q <= 1'b1;
            OP_SKIP: if (skip_take) pc_q <= pc_q + 1'b1;
            OP_JUMP: pc_q <= opnd;
            default: ;
          endcase
        end
        S_E1: begin
          if (op == OP_STORE)   mbr_q <= ac_q;
          else if (op == OP_IN) ac_q  <= in_q;
        end
        S_E2: if (op != OP_STORE) mbr_q <= mem_rdata_i;
        S_E3: ac_q <= (op == OP_LOAD) ? mbr_q : alu_res;
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbr_q;
  assign mem_we_o    = (step == S_E2) && (op == OP_STORE);
  assign out_data_o  = out_q;
  assign halted_o    = halt_q;
endmodule

// File: rtl/acc_cpu_sva.sv
module acc_cpu_sva
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input step_e         step_i,
  input logic [DW-1:0] ir_i,
  input logic [AW-1:0] pc_i,
  input logic [AW-1:0] mar_i,
  input logic [DW-1:0] ac_i,
  input logic [DW-1:0] mbr_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] out_data_o,
  input logic          halted_o
);
  AST_FETCH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i == S_F0 |=> mar_i == $past(pc_i)); // R2
  AST_PC_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i == S_INC |=> pc_i == AW'($past(pc_i) + 1'b1)); // R2
  AST_LOAD_AC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == S_E3 && ir_i[DW-1 -: 4] == OP_LOAD) |=> ac_i == $past(mbr_i)); // R3
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R4
  AST_JUMP_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == S_E0 && ir_i[DW-1 -: 4] == OP_JUMP) |=> pc_i == $past(ir_i[AW-1:0])); // R7
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(mem_addr_o) && $stable(out_data_o) && !mem_we_o)); // R8
endmodule

bind acc_cpu acc_cpu_sva #(.DW(DW), .AW(AW)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_i     (step),
  .ir_i       (ir_q),
  .pc_i       (pc_q),
  .mar_i      (mar_q),
  .ac_i       (ac_q),
  .mbr_i      (mbr_q),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .out_data_o (out_data_o),
  .halted_o   (halted_o)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [11:0] a;
    logic [15:0] d;
    string       req;
  } wr_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, in_data, out_data;
  logic        mem_we, halted;
  logic [15:0] mem [256];
  wr_t         exp_q[$];
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .in_data_i(in_data),
    .out_data_o(out_data), .halted_o(halted)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] a, input logic [15:0] d, input string req);
    wr_t w;
    w.a = a; w.d = d; w.req = req;
    exp_q.push_back(w);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected write", {4'h0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        wr_t w;
        w = exp_q.pop_front();
        chk(mem_addr == w.a && mem_wdata == w.d, w.req,
            {4'h0, mem_addr, mem_wdata}, {4'h0, w.a, w.d});
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(halted, req, {31'h0, halted}, 32'h1);
  endtask

  initial begin
    logic [11:0] a_hold;
    in_data = 16'h1234;
    clear_mem();
    mem[0]  = 16'h1040; mem[1]  = 16'h3041; mem[2]  = 16'h2050; mem[3]  = 16'h4042;
    mem[4]  = 16'h2051; mem[5]  = 16'h8000; mem[6]  = 16'h2052; mem[7]  = 16'h8400;
    mem[8]  = 16'h2053; mem[9]  = 16'h8C00; mem[10] = 16'h900C; mem[11] = 16'h2054;
    mem[12] = 16'h5000; mem[13] = 16'h6000; mem[14] = 16'h2055; mem[15] = 16'h8C00;
    mem[16] = 16'h2056; mem[17] = 16'h1043; mem[18] = 16'h8400; mem[19] = 16'h2057;
    mem[20] = 16'hA000; mem[21] = 16'hF0FF; mem[22] = 16'h205B; mem[23] = 16'h1045;
    mem[24] = 16'h3046; mem[25] = 16'h2058; mem[26] = 16'h8800; mem[27] = 16'h2059;
    mem[28] = 16'h7000; mem[29] = 16'h205A;
    mem[8'h40] = 16'd5; mem[8'h41] = 16'd7; mem[8'h42] = 16'd20;
    mem[8'h43] = 16'h0000; mem[8'h45] = 16'hFFFF; mem[8'h46] = 16'h0001;

    push(12'h050, 16'h000C, "R3 load+add");
    push(12'h051, 16'hFFF8, "R3 sub negative");
    push(12'h053, 16'hFFF8, "R6 skip 00 taken / 01 not taken");
    push(12'h055, 16'h1234, "R7 jump then R5 input");
    push(12'h05B, 16'h0000, "R9 no-op opcodes keep AC, R6 skip 11/01 taken");
    push(12'h058, 16'h0000, "R3 add wraps");
    push(12'h059, 16'h0000, "R6 code 10 never skips");

    repeat (3) @(negedge clk);
    chk(mem_addr == 12'h0, "R1 addr in reset", {20'h0, mem_addr}, 32'h0);
    chk(!mem_we, "R1 we in reset", {31'h0, mem_we}, 32'h0);
    chk(out_data == 16'h0, "R1 out in reset", {16'h0, out_data}, 32'h0);
    chk(!halted, "R1 halted in reset", {31'h0, halted}, 32'h0);
    rst_n = 1'b1;

    wait_halt("R8 halt reached");
    chk(out_data == 16'h1234, "R5 output port", {16'h0, out_data}, 32'h1234);
    a_hold = mem_addr;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(halted && !mem_we && mem_addr == a_hold && out_data == 16'h1234,
          "R8 frozen after halt", {19'h0, halted, mem_we, mem_addr}, {19'h4, 1'b0, a_hold});
    end
    chk(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 32'h0);
    chk(mem[8'h54] == 16'h0, "R7 word after jump skipped", {16'h0, mem[8'h54]}, 32'h0);

    // second program: phase timing
    rst_n = 1'b0;
    clear_mem();
    mem[0] = 16'h2060; mem[1] = 16'h7000;
    push(12'h060, 16'h0000, "R4 store after reset");
    @(negedge clk);
    chk(!halted && out_data == 16'h0, "R1 halt and output cleared", {15'h0, halted, out_data}, 32'h0);
    rst_n = 1'b1;
    chk(mem_addr == 12'h0, "R1 fetch from 0", {20'h0, mem_addr}, 32'h0);
    repeat (5) @(negedge clk);
    chk(!mem_we, "R2 no write in cycle 6", {31'h0, mem_we}, 32'h0);
    @(negedge clk);
    chk(mem_we && mem_addr == 12'h060, "R2 write in cycle 7", {19'h0, mem_we, mem_addr}, {19'h1, 12'h060});
    @(negedge clk);
    chk(!mem_we, "R4 one-cycle write", {31'h0, mem_we}, 32'h0);
    wait_halt("R8 halt in program 2");
    chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule